// File: doc/BRIEF.md
# Multifunction ALU with Funnel Shifter

A purely combinational integer ALU for a single-cycle datapath. Three units work in parallel on operands `op_a` and `op_b`: a logic unit, an adder that can also subtract, and a shifter. A two-bit unit select picks which of them, or a set-less-than value taken from the adder, drives the result. The block also produces a zero flag for the result and a signed-overflow flag for the adder.

The shifter is a single network that only shifts right. It works on a word of width 2W-1 and passes it through one 2:1 stage per bit of the shift amount. The operation code decides how `op_a` is widened to 2W-1 bits. For a left shift, the amount fed to the stages is the bitwise complement of the requested amount. A controller sets `arith_sub` for subtraction and for set-less-than, and sets `shift_op` and `logic_op` for their units.

Top module: `alu_funnel`

## Requirements
- R1: With `unit_sel`=11, the result is the logic unit output chosen by `logic_op`: 00 AND, 01 OR, 10 NOR, 11 XOR of `op_a` and `op_b`.
- R2: With `unit_sel`=10, the result is `op_a`+`op_b` modulo 2^W when `arith_sub`=0 and `op_a`-`op_b` modulo 2^W when `arith_sub`=1.
- R3: `ovf` is 1 exactly when the signed add (`arith_sub`=0) or signed subtract (`arith_sub`=1) of `op_a` and `op_b` overflows. It follows the adder whichever unit `unit_sel` picks.
- R4: With `unit_sel`=01 and `arith_sub`=1, result bit 0 is 1 when `op_a` < `op_b` as signed numbers, and all other result bits are 0.
- R5: With `unit_sel`=00 and `shift_op`=01, the result is `op_a` shifted right logically by `shamt` (zeros fill from the top).
- R6: With `unit_sel`=00 and `shift_op`=10, the result is `op_a` shifted right arithmetically by `shamt` (copies of bit W-1 fill from the top).
- R7: With `unit_sel`=00 and `shift_op`=11, the result is `op_a` rotated right by `shamt`. An amount of 0 returns `op_a` unchanged.
- R8: With `unit_sel`=00 and `shift_op`=00, the result is `op_a` shifted left by `shamt` with zero fill. An amount of 0 returns `op_a` unchanged, and an amount of W-1 leaves only bit 0 of `op_a` in bit W-1.
- R9: `zero` is 1 exactly when every bit of `result` is 0.
- R10: The unit select codes are 00 shifter, 01 set-less-than, 10 adder and 11 logic unit. Changing `unit_sel` with the other inputs held changes which of these values appears on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | First operand; the only data input of the shifter |
| op_b | input | W | Second operand |
| shamt | input | $clog2(W) | Shift or rotate amount |
| unit_sel | input | 2 | Result source select |
| logic_op | input | 2 | Logic unit operation |
| arith_sub | input | 1 | 0 add, 1 subtract |
| shift_op | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| result | output | W | Selected result |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow of the adder |

## Verification
The bound checker holds on every evaluation for several properties: the zero flag, the cleared upper bits of the set-less-than result, the sign relations that any signed overflow must show, and the identity of a rotate or left shift by zero. The exact value of each shift and rotate at every amount, the sums and differences at the signed limits, the overflow flag under other unit selects, and the result select mapping are shown only by the bench sweeps. The bench computes these expected values with native operators and compares them with the outputs.

// File: rtl/alu_funnel.sv
module alu_funnel #(
  parameter int W = 32
) (
  input  logic [W-1:0]         op_a,
  input  logic [W-1:0]         op_b,
  input  logic [$clog2(W)-1:0] shamt,
  input  logic [1:0]           unit_sel,
  input  logic [1:0]           logic_op,
  input  logic                 arith_sub,
  input  logic [1:0]           shift_op,
  output logic [W-1:0]         result,
  output logic                 zero,
  output logic                 ovf
);
  localparam int SW = $clog2(W);
  localparam int EW = 2 * W - 1;

  // adder / subtractor
  logic [W-1:0] b_eff, sum;
  assign b_eff = op_b ^ {W{arith_sub}};
  assign sum   = op_a + b_eff + {{(W-1){1'b0}}, arith_sub};
  assign ovf   = (op_a[W-1] == b_eff[W-1]) && (sum[W-1] != op_a[W-1]);

  logic [W-1:0] slt_val;
  assign slt_val = {{(W-1){1'b0}}, sum[W-1] ^ ovf};

  // logic unit
  logic [W-1:0] logic_val;
  always_comb begin
    case (logic_op)
      2'b00:   logic_val = op_a & op_b;
      2'b01:   logic_val = op_a | op_b;
      2'b10:   logic_val = ~(op_a | op_b);
      default: logic_val = op_a ^ op_b;
    endcase
  end

  // funnel shifter: widen, then right-shift only
  logic [EW-1:0] ext;
  always_comb begin
    case (shift_op)
      2'b00:   ext = {op_a, {(W-1){1'b0}}};
      2'b01:   ext = {{(W-1){1'b0}}, op_a};
      2'b10:   ext = {{(W-1){op_a[W-1]}}, op_a};
      default: ext = {op_a[W-2:0], op_a};
    endcase
  end

  logic [SW-1:0] amt;
  assign amt = (shift_op == 2'b00) ? ~shamt : shamt;

  logic [EW-1:0] stage [SW+1];
  assign stage[SW] = ext;
  for (genvar k = SW - 1; k >= 0; k--) begin : g_stage
    assign stage[k] = amt[k] ? (stage[k+1] >> (1 << k)) : stage[k+1];
  end

  logic [W-1:0] shift_val;
  assign shift_val = stage[0][W-1:0];

  always_comb begin
    case (unit_sel)
      2'b00:   result = shift_val;
      2'b01:   result = slt_val;
      2'b10:   result = sum;
      default: result = logic_val;
    endcase
  end

  assign zero = (result == '0);
endmodule

// File: rtl/alu_funnel_chk.sv
module alu_funnel_chk #(
  parameter int W = 32
) (
  input logic [W-1:0]         op_a,
  input logic [W-1:0]         op_b,
  input logic [$clog2(W)-1:0] shamt,
  input logic [1:0]           unit_sel,
  input logic                 arith_sub,
  input logic [1:0]           shift_op,
  input logic [W-1:0]         result,
  input logic                 zero,
  input logic                 ovf
);
  always_comb begin
    a_r9_zero_flag: assert (zero == (result == '0));
    if (unit_sel == 2'b01)
      a_r4_slt_upper_clear: assert (result[W-1:1] == '0);
    if (ovf)
      a_r3_ovf_signs: assert ((op_a[W-1] ^ op_b[W-1]) == arith_sub);
    if (unit_sel == 2'b00 && shamt == '0 && shift_op == 2'b11)
      a_r7_ror_zero_identity: assert (result == op_a);
    if (unit_sel == 2'b00 && shamt == '0 && shift_op == 2'b00)
      a_r8_sll_zero_identity: assert (result == op_a);
  end
endmodule

bind alu_funnel alu_funnel_chk #(.W(W)) chk (
  .op_a(op_a), .op_b(op_b), .shamt(shamt), .unit_sel(unit_sel),
  .arith_sub(arith_sub), .shift_op(shift_op), .result(result),
  .zero(zero), .ovf(ovf)
);

// File: tb/alu_funnel_test.sv
module alu_funnel_test;
  logic clk = 0;
  always #5 clk = ~clk;

  logic [31:0] a, b, res;
  logic [4:0]  sa;
  logic [1:0]  usel, lop, sop;
  logic        sub, zf, of;
  int tests = 0, fails = 0;

  alu_funnel #(.W(32)) uut (
    .op_a(a), .op_b(b), .shamt(sa), .unit_sel(usel), .logic_op(lop),
    .arith_sub(sub), .shift_op(sop), .result(res), .zero(zf), .ovf(of)
  );

  function automatic logic [31:0] pat(int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      5: return 32'hA5A5_3C3C;
      6: return 32'h1234_5678;
      default: return 32'hFEDC_BA98;
    endcase
  endfunction

  task automatic apply(logic [31:0] ia, logic [31:0] ib, logic [4:0] isa,
                       logic [1:0] iu, logic [1:0] il, logic is, logic [1:0] iso);
    @(negedge clk);
    a = ia; b = ib; sa = isa; usel = iu; lop = il; sub = is; sop = iso;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h sa=%0d got=%h exp=%h", req, a, b, sa, got, exp);
    end
  endtask

  function automatic logic exp_ovf(logic [31:0] x, logic [31:0] y, logic s);
    logic [32:0] r;
    r = s ? ({x[31], x} - {y[31], y}) : ({x[31], x} + {y[31], y});
    return r[32] ^ r[31];
  endfunction

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    a = 0; b = 0; sa = 0; usel = 0; lop = 0; sub = 0; sop = 0;
    // all-zero inputs: shifter output 0, zero flag set (R9)
    apply(0, 0, 0, 2'b00, 2'b00, 1'b0, 2'b01);
    chk("R9 idle", {31'b0, zf}, 32'd1);

    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        logic [31:0] x, y;
        x = pat(i); y = pat(j);
        for (int l = 0; l < 4; l++) begin
          logic [31:0] e;
          apply(x, y, 0, 2'b11, 2'(l), 1'b0, 2'b00);
          e = (l == 0) ? (x & y) : (l == 1) ? (x | y) : (l == 2) ? ~(x | y) : (x ^ y);
          chk("R1 logic", res, e);
          chk("R9 zero", {31'b0, zf}, {31'b0, e == 0});
        end
        for (int s = 0; s < 2; s++) begin
          apply(x, y, 0, 2'b10, 2'b00, 1'(s), 2'b00);
          chk("R2 addsub", res, s ? x - y : x + y);
          chk("R3 ovf", {31'b0, of}, {31'b0, exp_ovf(x, y, 1'(s))});
          // R3: overflow still reported with the shifter selected
          apply(x, y, 0, 2'b00, 2'b00, 1'(s), 2'b01);
          chk("R3 ovf other unit", {31'b0, of}, {31'b0, exp_ovf(x, y, 1'(s))});
        end
        apply(x, y, 0, 2'b01, 2'b00, 1'b1, 2'b00);
        chk("R4 slt", res, {31'b0, $signed(x) < $signed(y)});
      end

    for (int i = 0; i < 8; i++)
      for (int n = 0; n < 32; n++) begin
        logic [31:0] x;
        x = pat(i);
        apply(x, 0, 5'(n), 2'b00, 2'b00, 1'b0, 2'b01);
        chk("R5 srl", res, x >> n);
        apply(x, 0, 5'(n), 2'b00, 2'b00, 1'b0, 2'b10);
        chk("R6 sra", res, 32'($signed(x) >>> n));
        apply(x, 0, 5'(n), 2'b00, 2'b00, 1'b0, 2'b11);
        chk("R7 ror", res, (x >> n) | (x << (32 - n)));
        apply(x, 0, 5'(n), 2'b00, 2'b00, 1'b0, 2'b00);
        chk("R8 sll", res, x << n);
        chk("R9 zero shift", {31'b0, zf}, {31'b0, (x << n) == 0});
      end
    apply(32'h0000_0001, 0, 5'd31, 2'b00, 2'b00, 1'b0, 2'b00);
    chk("R8 sll max", res, 32'h8000_0000);

    // R10: same inputs, each select code
    for (int u = 0; u < 4; u++) begin
      logic [31:0] e;
      apply(32'h8000_0010, 32'h0000_0003, 5'd4, 2'(u), 2'b01, 1'b1, 2'b01);
      e = (u == 0) ? 32'h0800_0001 : (u == 1) ? 32'd1 :
          (u == 2) ? 32'h8000_000D : 32'h8000_0013;
      chk("R10 select", res, e);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule